// File: doc/BRIEF.md
# SDRAM Refresh Scheduler and Clock-Enable Manager

This block sits beside the main command sequencer of an SDRAM controller. A period timer counts clock cycles and, each time the programmed period elapses, raises a refresh request that stays up until the sequencer acknowledges it. The timer runs only while at least one memory channel is enabled and the programmed period is nonzero. A small countdown, loaded by software, drops by one on every acknowledged refresh and stops at zero. Initialization firmware polls it to know when the required number of start-up refreshes has been issued.

The block also drives the SDRAM clock-enable line. In automatic power-down mode the line falls while the controller is idle and nothing is waiting. It rises again as soon as an access, a command or a refresh request appears. A ready output tells the sequencer when the line has been high long enough to issue a command. An advance option moves every clock-enable edge one cycle earlier.

Top module: `dram_refresh_pd`

## Requirements
- R1: After reset the period is 0x30C. With the timer running, the refresh request rises exactly P cycles after the last reload, where P is the active period. A reload happens when reset is released and on every acknowledge edge.
- R2: Once raised, the refresh request stays high until `ref_ack_i` is sampled high. It is low in the cycle after that acknowledge.
- R3: While every bit of `chan_en_i` is 0, the elapsed count holds and no new refresh request is raised.
- R4: Each cycle with `ref_ack_i` high lowers the countdown by one. At zero the countdown stays at zero and never wraps.
- R5: A configuration write (`cfg_we_i`) loads four fields from `cfg_wdata_i`:
  - the period from bits [11:0]
  - the countdown from bits [17:12]
  - the power-down enable from bit [18]
  - the advance enable from bit [19]

  A nonzero countdown load restarts the countdown.
- R6: With power-down enabled and advance off, `cke_o` goes low one cycle after `ctrl_idle_i` is high with no wake source present. The wake sources are `op_pend_i` and a pending refresh request. `cke_o` goes high one cycle after a wake source appears.
- R7: With advance on, each `cke_o` transition of R6 happens in the same cycle as its cause, which is one cycle earlier.
- R8: Reset leaves power-down off, advance off, the countdown at 0, the request low, `cke_o` high and `cmd_ready_o` high.
- R9: `cmd_ready_o` is high exactly when `cke_o` is high now and was high in the previous cycle.
- R10: A period written while the timer runs takes effect at the next reload, or at once while the timer is stopped.
- R11: A programmed period of 0 stops refresh generation: no new request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 20 | Configuration write data (fields in R5) |
| chan_en_i | input | NCH | Memory channel enables |
| ctrl_idle_i | input | 1 | Main sequencer is idle |
| op_pend_i | input | 1 | An access or command is waiting |
| ref_ack_i | input | 1 | Refresh has been completed |
| ref_req_o | output | 1 | Refresh request |
| cke_o | output | 1 | SDRAM clock enable |
| cmd_ready_o | output | 1 | Clock enable is stable; a command may be issued |
| init_cnt_o | output | 6 | Refresh countdown value |

## Verification
The assertions take for granted that the sequencer pulses `ref_ack_i` only to report a finished refresh. They also assume that `op_pend_i` and `ctrl_idle_i` are plain levels, free of glitches between edges. The stimulus pulses the acknowledge for one cycle only after a request has been observed, apart from the countdown checks, where each isolated pulse stands for one finished refresh. Channel enables, idle and pending levels are changed only at the falling clock edge. Random periods are drawn from 2 to 31 so that every interval can be measured within the run.

// File: rtl/dram_ref_pkg.sv
`timescale 1ns/1ps
package dram_ref_pkg;
  localparam int PERIOD_W = 12;
  localparam int CNT_W    = 6;
  localparam logic [PERIOD_W-1:0] PERIOD_RST = 12'h30C;
  localparam int CFG_W    = PERIOD_W + CNT_W + 2;

  typedef struct packed {
    logic                adv_en;
    logic                pd_en;
    logic [CNT_W-1:0]    cnt;
    logic [PERIOD_W-1:0] period;
  } cfg_t;
endpackage

// File: rtl/ref_timer.sv
`timescale 1ns/1ps
module ref_timer
  import dram_ref_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                period_we_i,
  input  logic [PERIOD_W-1:0] period_i,
  input  logic                chan_any_i,
  input  logic                ack_i,
  output logic                req_o
);
  logic [PERIOD_W-1:0] period_q, cur_q, elapsed_q;
  logic req_q, active;

  assign active = chan_any_i && (period_q != '0) && (cur_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q  <= PERIOD_RST;
      cur_q     <= PERIOD_RST;
      elapsed_q <= '0;
      req_q     <= 1'b0;
    end else begin
      if (period_we_i) period_q <= period_i;
      if (ack_i) begin
        req_q     <= 1'b0;
        elapsed_q <= '0;
        cur_q     <= period_q;
      end else if (!active) begin
        // stopped: hold count, pick up new period
        cur_q <= period_q;
        if (cur_q == '0) elapsed_q <= '0;
      end else if (!req_q) begin
        if (elapsed_q >= cur_q - PERIOD_W'(1)) begin
          req_q     <= 1'b1;
          elapsed_q <= '0;
        end else begin
          elapsed_q <= elapsed_q + PERIOD_W'(1);
        end
      end
    end
  end

  assign req_o = req_q;

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_q && !ack_i |=> req_q); // R2
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !req_q); // R2
  AST_NO_REQ_CH_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !chan_any_i && !req_q |=> !req_q); // R3
  AST_ZERO_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    period_q == '0 && !req_q |=> !req_q); // R11
endmodule

// File: rtl/init_countdown.sv
`timescale 1ns/1ps
module init_countdown
  import dram_ref_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  input  logic             ack_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (load_i)                 cnt_q <= val_i;
    else if (ack_i && cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
  end

  assign cnt_o = cnt_q;

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && cnt_q == '0 |=> cnt_q == '0); // R4
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i && ack_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R4
endmodule

// File: rtl/cke_ctrl.sv
`timescale 1ns/1ps
module cke_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pd_en_i,
  input  logic adv_i,
  input  logic idle_i,
  input  logic wake_i,
  output logic cke_o,
  output logic ready_o
);
  logic cke_want, cke_r, cke_prev;

  assign cke_want = !(pd_en_i && idle_i && !wake_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cke_r    <= 1'b1;
      cke_prev <= 1'b1;
    end else begin
      cke_r    <= cke_want;
      cke_prev <= cke_o;
    end
  end

  // advance mode bypasses the output register
  assign cke_o   = adv_i ? cke_want : cke_r;
  assign ready_o = cke_o && cke_prev;

  AST_READY_NEEDS_CKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cke_o && $past(cke_o)); // R9
  AST_WAKE_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i && wake_i |=> (cke_o || adv_i)); // R6
  AST_WAKE_ADV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && wake_i |-> cke_o); // R7
endmodule

// File: rtl/dram_refresh_pd.sv
`timescale 1ns/1ps
module dram_refresh_pd
  import dram_ref_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  input  logic [NCH-1:0]   chan_en_i,
  input  logic             ctrl_idle_i,
  input  logic             op_pend_i,
  input  logic             ref_ack_i,
  output logic             ref_req_o,
  output logic             cke_o,
  output logic             cmd_ready_o,
  output logic [CNT_W-1:0] init_cnt_o
);
  cfg_t wcfg;
  logic pd_q, adv_q, req;

  assign wcfg = cfg_t'(cfg_wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pd_q  <= 1'b0;
      adv_q <= 1'b0;
    end else if (cfg_we_i) begin
      pd_q  <= wcfg.pd_en;
      adv_q <= wcfg.adv_en;
    end
  end

  ref_timer i_timer (
    .clk_i, .rst_ni,
    .period_we_i (cfg_we_i),
    .period_i    (wcfg.period),
    .chan_any_i  (|chan_en_i),
    .ack_i       (ref_ack_i),
    .req_o       (req)
  );

  init_countdown i_count (
    .clk_i, .rst_ni,
    .load_i (cfg_we_i),
    .val_i  (wcfg.cnt),
    .ack_i  (ref_ack_i),
    .cnt_o  (init_cnt_o)
  );

  cke_ctrl i_cke (
    .clk_i, .rst_ni,
    .pd_en_i (pd_q),
    .adv_i   (adv_q),
    .idle_i  (ctrl_idle_i),
    .wake_i  (op_pend_i || req),
    .cke_o   (cke_o),
    .ready_o (cmd_ready_o)
  );

  assign ref_req_o = req;
endmodule

// File: tb/test_dram_refresh_pd.sv
`timescale 1ns/1ps
module test_dram_refresh_pd;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [19:0] cfg_wdata = '0;
  logic [1:0] chan_en = 2'b01;
  logic idle = 1'b0, op_pend = 1'b0, ack = 1'b0;
  logic req, cke, ready;
  logic [5:0] cnt;
  int checks = 0, errors = 0, n = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dram_refresh_pd i_dram_refresh_pd (
    .clk_i(clk), .rst_ni(rst_n), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .chan_en_i(chan_en), .ctrl_idle_i(idle), .op_pend_i(op_pend),
    .ref_ack_i(ack), .ref_req_o(req), .cke_o(cke), .cmd_ready_o(ready),
    .init_cnt_o(cnt));

  function automatic int exp_count(int start, int acks);
    return (acks >= start) ? 0 : start - acks;
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic cyc(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wr(input int period, input int c, input bit pd, input bit adv);
    cfg_wdata = {adv, pd, 6'(c), 12'(period)};
    cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  task automatic wait_req(output int cycles);
    cycles = 0;
    while (!req && cycles < 3000) begin
      @(negedge clk);
      cycles++;
    end
  endtask

  initial begin
    void'($urandom(32'd4937));
    cyc(3);
    chk(req == 1'b0, "R8", req, 0);
    chk(cke == 1'b1 && ready == 1'b1, "R8", cke, 1);
    chk(cnt == 6'd0, "R8", cnt, 0);
    rst_n = 1'b1;
    // R1 default period from reset release
    wait_req(n);
    chk(n == 32'h30C, "R1", n, 32'h30C);
    cyc(5);
    chk(req == 1'b1, "R2", req, 1);
    // R10: new period applies on reload
    wr(10, 0, 0, 0);
    pulse_ack();
    chk(req == 1'b0, "R2", req, 0);
    wait_req(n);
    chk(n == 10, "R10", n, 10);
    pulse_ack();
    cyc(2);
    wr(6, 0, 0, 0);
    wait_req(n);
    chk(n == 7, "R10", n + 3, 10);
    pulse_ack();
    wait_req(n);
    chk(n == 6, "R1", n, 6);
    // random periods
    for (int i = 0; i < 6; i++) begin
      int p;
      p = 2 + int'($urandom % 30);
      wr(p, 0, 0, 0);
      pulse_ack();
      wait_req(n);
      chk(n == p, "R1", n, p);
    end
    // R3: channels off
    wr(20, 0, 0, 0);
    pulse_ack();
    cyc(5);
    chan_en = 2'b00;
    cyc(60);
    chk(req == 1'b0, "R3", req, 0);
    chan_en = 2'b10;
    wait_req(n);
    chk(n == 15, "R3", n, 15);
    // R11: zero period
    wr(0, 0, 0, 0);
    pulse_ack();
    cyc(100);
    chk(req == 1'b0, "R11", req, 0);
    // R4 / R5 countdown
    wr(0, 3, 0, 0);
    chk(cnt == 6'd3, "R5", cnt, 3);
    for (int i = 1; i <= 5; i++) begin
      pulse_ack();
      chk(cnt == 6'(exp_count(3, i)), "R4", cnt, exp_count(3, i));
    end
    wr(0, 0, 0, 0);
    pulse_ack();
    chk(cnt == 6'd0, "R4", cnt, 0);
    for (int i = 0; i < 4; i++) begin
      int c, k;
      c = 1 + int'($urandom % 20);
      k = int'($urandom % 25);
      wr(0, c, 0, 0);
      repeat (k) pulse_ack();
      chk(cnt == 6'(exp_count(c, k)), "R5", cnt, exp_count(c, k));
    end
    // R6 / R9 normal power-down
    idle = 1'b1;
    cyc(3);
    chk(cke == 1'b1, "R8", cke, 1);
    wr(0, 0, 1, 0);
    chk(cke == 1'b1, "R6", cke, 1);
    cyc(1);
    chk(cke == 1'b0 && ready == 1'b0, "R6", cke, 0);
    op_pend = 1'b1;
    cyc(1);
    chk(cke == 1'b1, "R6", cke, 1);
    chk(ready == 1'b0, "R9", ready, 0);
    cyc(1);
    chk(ready == 1'b1, "R9", ready, 1);
    op_pend = 1'b0;
    idle = 1'b0;
    cyc(3);
    chk(cke == 1'b1, "R6", cke, 1);
    idle = 1'b1;
    cyc(1);
    chk(cke == 1'b0, "R6", cke, 0);
    // refresh request wakes CKE
    wr(8, 0, 1, 0);
    wait_req(n);
    chk(cke == 1'b0, "R6", cke, 0);
    cyc(1);
    chk(cke == 1'b1, "R6", cke, 1);
    pulse_ack();
    cyc(1);
    chk(cke == 1'b0, "R6", cke, 0);
    // R7 advanced
    wr(0, 0, 1, 1);
    pulse_ack();
    chk(cke == 1'b0, "R7", cke, 0);
    op_pend = 1'b1;
    #1;
    chk(cke == 1'b1, "R7", cke, 1);
    chk(ready == 1'b0, "R9", ready, 0);
    cyc(1);
    chk(ready == 1'b1, "R9", ready, 1);
    op_pend = 1'b0;
    #1;
    chk(cke == 1'b0, "R7", cke, 0);
    // power-down off keeps CKE high while idle
    wr(0, 0, 0, 0);
    cyc(2);
    chk(cke == 1'b1 && ready == 1'b1, "R8", cke, 1);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule